// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Detection

A memory-mapped general-purpose I/O controller for up to 32 pins. Software reaches it through a simple 32-bit register bus. Each pin has three things: a direction bit, an output level, and a readable current level. Input levels pass through a two-stage synchronizer before they are used.

Every pin can also raise an interrupt. The trigger is chosen per pin from these modes: active-high level, active-low level, rising edge, falling edge, or either edge. The mode is spread over three registers: a level/edge select, a polarity, and an any-edge override. A trigger sets a sticky per-pin pending bit, which software clears by writing ones. A per-pin enable masks the pending bits, and the enabled bits are ORed into one interrupt line. A read-only version register reports 3, which tells software that the any-edge mode is present.

The register bus has no handshake. A write lands on the clock edge where `bus_wr` is sampled high. Read data is a combinational function of `bus_addr`. There is no stream traffic, so no back-pressure rules apply.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Registers sit at byte offsets 0x00 pin level, 0x04 direction, 0x08 interrupt enable, 0x0C masked status, 0x10 pending, 0x14 clear, 0x18 edge select, 0x1C polarity, 0x20 version, 0x24 any-edge. Bit n of each refers to pin n. After reset, direction reads all ones, enable reads 0 and the interrupt output is low.
- R2: A direction bit of 0 makes pin n an output: `pin_oe[n]` is 1 and `pin_out[n]` follows bit n of the last value written at 0x00. A direction bit of 1 makes the pin an input with `pin_oe[n]` at 0.
- R3: Reading 0x00 returns the synchronized input level for input pins and the written value for output pins.
- R4: With edge select 0, polarity 1 triggers while the pin is high and polarity 0 triggers while it is low. The pending bit is set again on every cycle the level stays active.
- R5: With edge select 1 and any-edge 0, polarity 1 triggers on a rising edge and polarity 0 on a falling edge. A steady pin never triggers.
- R6: With edge select 1 and any-edge 1, both edges trigger regardless of polarity. With edge select 0, the any-edge bit has no effect.
- R7: A pin change applied before clock edge k is seen as pending after edge k+2 and not after edge k+1.
- R8: Writing 1 to bit n at 0x14 clears pending bit n. Writing 0 has no effect. Pending bits otherwise stay set. Offset 0x14 reads 0.
- R9: When a clear and a new trigger for the same pin fall on the same edge, the pending bit stays set.
- R10: The interrupt output is high exactly when some pin is both pending and enabled. Offset 0x0C reads pending AND enable. Clearing the enable masks the output without losing pending bits.
- R11: Offset 0x20 reads 3. Writes to 0x0C, 0x10 and 0x20 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Output levels to the pads |
| pin_oe | output | NPINS | Output enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
A software clear and a fresh trigger for the same pin can land on the same clock edge. The bench provokes this by raising a pin in rising-edge mode. It then times a write of 1 to the clear register so that the write is sampled on the edge where the synchronized edge is detected. The pending bit must read 1 afterwards. A clear written later, with no trigger present, must then take it to 0. Level modes produce the same collision in every sweep step, because a clear issued while the level is active must leave the bit set.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_LEVEL  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR    = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_ENABLE = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_PEND   = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_CLEAR  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_EDGSEL = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_POLAR  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_VER    = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_ANYEDG = 6'h24;

  localparam logic [DATA_W-1:0] HW_VERSION = 32'd3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_async;
      stab_q <= meta_q;
    end
  end

  assign d_sync = stab_q;
endmodule

// File: rtl/gpio_trig.sv
module gpio_trig #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] lvl,
  input  logic [NPINS-1:0] edge_sel,
  input  logic [NPINS-1:0] polarity,
  input  logic [NPINS-1:0] any_edge,
  output logic [NPINS-1:0] trig
);
  logic [NPINS-1:0] lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= '0;
    else        lvl_d <= lvl;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic rise, fall, lvl_hit;
    always_comb begin
      rise    = lvl[i] & ~lvl_d[i];
      fall    = ~lvl[i] & lvl_d[i];
      lvl_hit = (lvl[i] == polarity[i]);
      if (!edge_sel[i])     trig[i] = lvl_hit;
      else if (any_edge[i]) trig[i] = rise | fall;
      else                  trig[i] = polarity[i] ? rise : fall;
    end

    // R5
    edge_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_sel[i] && (lvl[i] == lvl_d[i])) |-> !trig[i]);
  end
endmodule

// File: rtl/gpio_pend.sv
module gpio_pend #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] trig,
  input  logic [NPINS-1:0] clr_mask,
  input  logic [NPINS-1:0] enable,
  output logic [NPINS-1:0] pend,
  output logic             irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_mask) | trig;
  end

  assign irq = |(pend & enable);

  // R9
  trig_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig) |=> ((pend & $past(trig)) == $past(trig)));

  // R8
  clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask & ~trig)) |=> ((pend & $past(clr_mask & ~trig)) == '0));

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend) & ~$past(clr_mask) & ~pend) == '0);

  // R4
  set_by_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~$past(pend) & ~$past(trig)) == '0);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  localparam logic [NPINS-1:0] ALL_IN = {NPINS{1'b1}};

  logic [NPINS-1:0] wval;
  logic [NPINS-1:0] dir_q, out_q, en_q, esel_q, pol_q, any_q;
  logic [NPINS-1:0] lvl_s, trig, pend, clr_mask;

  assign wval = bus_wdata[NPINS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= ALL_IN;
      out_q  <= '0;
      en_q   <= '0;
      esel_q <= '0;
      pol_q  <= '0;
      any_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_LEVEL:  out_q  <= wval;
        OFS_DIR:    dir_q  <= wval;
        OFS_ENABLE: en_q   <= wval;
        OFS_EDGSEL: esel_q <= wval;
        OFS_POLAR:  pol_q  <= wval;
        OFS_ANYEDG: any_q  <= wval;
        default: ;
      endcase
    end
  end

  assign clr_mask = (bus_wr && bus_addr == OFS_CLEAR) ? wval : '0;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_in), .d_sync(lvl_s)
  );

  gpio_trig #(.NPINS(NPINS)) u_trig (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_s), .edge_sel(esel_q),
    .polarity(pol_q), .any_edge(any_q), .trig(trig)
  );

  gpio_pend #(.NPINS(NPINS)) u_pend (
    .clk(clk), .rst_n(rst_n), .trig(trig), .clr_mask(clr_mask),
    .enable(en_q), .pend(pend), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_LEVEL:  bus_rdata[NPINS-1:0] = (dir_q & lvl_s) | (~dir_q & out_q);
      OFS_DIR:    bus_rdata[NPINS-1:0] = dir_q;
      OFS_ENABLE: bus_rdata[NPINS-1:0] = en_q;
      OFS_STATUS: bus_rdata[NPINS-1:0] = pend & en_q;
      OFS_PEND:   bus_rdata[NPINS-1:0] = pend;
      OFS_EDGSEL: bus_rdata[NPINS-1:0] = esel_q;
      OFS_POLAR:  bus_rdata[NPINS-1:0] = pol_q;
      OFS_ANYEDG: bus_rdata[NPINS-1:0] = any_q;
      OFS_VER:    bus_rdata = HW_VERSION;
      default:    bus_rdata = '0;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;

  // R10
  mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

  // R1
  dir_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0));
endmodule

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam logic [5:0] A_LVL = 6'h00, A_DIR = 6'h04, A_EN = 6'h08,
    A_ST = 6'h0C, A_PEND = 6'h10, A_CLR = 6'h14, A_SEL = 6'h18,
    A_POL = 6'h1C, A_VER = 6'h20, A_ANY = 6'h24;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NP-1:0] pin_in = '0, pin_out, pin_oe;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_ctrl #(.NPINS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // mode: 0 level-high, 1 level-low, 2 rise, 3 fall, 4 any edge, 5 level-high with any-edge bit
  function automatic bit active(input int m, input bit v);
    if (m == 0 || m == 5) return v;
    if (m == 1) return !v;
    return 0;
  endfunction
  function automatic bit fires(input int m, input bit a, input bit b);
    if (m == 2) return !a && b;
    if (m == 3) return a && !b;
    if (m == 4) return a != b;
    return 0;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    idle(3); rst_n = 1; idle(1);
    // R1 reset state
    rd(A_DIR, r); chk("R1 dir reset", r, 32'hFF);
    rd(A_EN, r);  chk("R1 enable reset", r, 0);
    chk("R1 irq reset", {31'd0, irq}, 0);
    chk("R2 oe reset", {24'd0, pin_oe}, 0);
    // R11 version
    rd(A_VER, r); chk("R11 version", r, 3);
    wr(A_VER, 32'h55); rd(A_VER, r); chk("R11 version write ignored", r, 3);

    // R4 R5 R6 sweep over every pin and mode
    for (int p = 0; p < NP; p++)
      for (int m = 0; m < 6; m++)
        for (int a = 0; a < 2; a++) begin
          bit sel, pol, any, b;
          sel = (m >= 2 && m <= 4); pol = (m == 0 || m == 2 || m == 5);
          any = (m == 4 || m == 5); b = !a;
          wr(A_SEL, {32{sel}}); wr(A_POL, {32{pol}}); wr(A_ANY, {32{any}});
          @(negedge clk); pin_in = NP'(a) << p;
          idle(5);
          wr(A_CLR, 32'd1 << p);
          rd(A_PEND, r);
          chk($sformatf("R4 R8 R9 pin%0d mode%0d after clear", p, m), r[p], active(m, a[0]));
          @(negedge clk); pin_in = NP'(b) << p;
          idle(5);
          rd(A_PEND, r);
          chk($sformatf("R4 R5 R6 pin%0d mode%0d in%0d->%0d", p, m, a, b), r[p],
              active(m, a[0]) | active(m, b) | fires(m, a[0], b));
        end

    // R7 latency, rising mode on pin 0
    wr(A_SEL, 32'hFF); wr(A_POL, 32'hFF); wr(A_ANY, 0);
    @(negedge clk); pin_in = '0; idle(5); wr(A_CLR, 32'hFF);
    @(negedge clk); bus_addr = A_PEND; pin_in = 8'h01;
    @(posedge clk); @(posedge clk); #1 chk("R7 not yet after two edges", bus_rdata[0], 0);
    @(posedge clk); #1 chk("R7 pending after third edge", bus_rdata[0], 1);

    // R9 collision: clear sampled on the edge that detects the new edge
    @(negedge clk); pin_in = '0; idle(5); wr(A_CLR, 32'hFF);
    @(negedge clk); pin_in = 8'h01;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_addr = A_CLR; bus_wdata = 32'h1; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    rd(A_PEND, r); chk("R9 trigger beats clear", r[0], 1);
    // R8 writing zero / to pending does nothing, read of clear is 0
    wr(A_CLR, 0); rd(A_PEND, r); chk("R8 zero clear no effect", r[0], 1);
    wr(A_PEND, 0); rd(A_PEND, r); chk("R11 pending write ignored", r[0], 1);
    rd(A_CLR, r); chk("R8 clear reads zero", r, 0);

    // R10 masking
    wr(A_EN, 0); rd(A_ST, r);
    chk("R10 masked irq", {31'd0, irq}, 0); chk("R10 masked status", r, 0);
    rd(A_PEND, r); chk("R10 pending kept", r[0], 1);
    wr(A_EN, 32'h2); chk("R10 other pin enabled", {31'd0, irq}, 0);
    wr(A_EN, 32'h3); rd(A_ST, r);
    chk("R10 irq unmasked", {31'd0, irq}, 1); chk("R10 status", r, 1);
    wr(A_ST, 0); rd(A_ST, r); chk("R11 status write ignored", r, 1);
    wr(A_CLR, 32'h1); rd(A_PEND, r); chk("R8 clear without trigger", r[0], 0);
    chk("R10 irq after clear", {31'd0, irq}, 0);

    // R2 R3 outputs and readback
    wr(A_DIR, 32'hF0); wr(A_LVL, 32'hA5);
    chk("R2 oe", {24'd0, pin_oe}, 32'h0F); chk("R2 pin_out", {24'd0, pin_out}, 32'hA5);
    @(negedge clk); pin_in = 8'h3C; idle(3);
    rd(A_LVL, r); chk("R3 level readback", r, 32'h35);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule